// File: doc/BRIEF.md
# Set/Clear Shadow Peripheral Register Bank

This block is the software-visible register front end of a peripheral on a 32-bit APB-style bus. Software sees five things through it. A write-one command register fires single-cycle pulses toward the peripheral core. A read/write mode register holds the peripheral's configuration. A read-only status word joins event bits latched from the core with the current feature-enable state. Two bit vectors, the feature enables and the interrupt mask, are each changed only through a pair of write addresses: one sets bits and one clears them. Software can therefore flip any bit with a single store and never needs a read-modify-write sequence.

The interrupt line goes high whenever any status bit is set while its mask bit is also set. Every register is reached as a full word. Sub-word addressing is folded onto the word that contains it.

Register offsets (byte address, bits [1:0] ignored):

| Offset | Access | Function |
|---|---|---|
| 0x00 | W | command: bits [CMD_W-1:0] pulse `cmd_pulse`, bit 31 clears latched events |
| 0x04 | R/W | mode, MODE_W bits |
| 0x08 | R | status: [EVT_W-1:0] latched events, [EVT_W+FEAT_W-1:EVT_W] feature state; read clears events |
| 0x10 | W | feature set |
| 0x14 | W | feature clear |
| 0x18 | R | feature state |
| 0x20 | W | interrupt-mask set |
| 0x24 | W | interrupt-mask clear |
| 0x28 | R | interrupt mask (one bit per status bit) |

Top module: `shadow_regbank`

## Requirements
- R1: Address bits [1:0] are ignored. An access at any byte of a word reaches that word's register with the full 32-bit data.
- R2: Writing offset 0x00 drives `cmd_pulse` high for exactly one cycle, in the cycle after the access edge, on each bit written as one. A zero write pulses nothing, and bit 31 never appears on `cmd_pulse`.
- R3: The mode register at 0x04 holds the low MODE_W bits written to it and returns them on read. It changes only when written.
- R4: A one written to 0x10 sets that feature bit, and a one written to 0x14 clears it. Zero bits leave the state unchanged. The state reads back at 0x18 and drives `feat_en`.
- R5: The interrupt mask is set by ones written to 0x20 and cleared by ones written to 0x24. It reads back at 0x28. Writes to 0x28 have no effect.
- R6: `irq` is high exactly when some status bit and its mask bit are both one.
- R7: Status bits [EVT_W-1:0] are the latched events and bits [EVT_W+FEAT_W-1:EVT_W] mirror the feature state. Writes to 0x08 have no effect.
- R8: A pulse on `evt_in` latches its bit until a status read or a command write with bit 31 set. When a new event arrives in the same cycle as the clear, the new event stays latched.
- R9: Write-only offsets, unmapped offsets and unused upper bits all read as zero.
- R10: After reset, every register, `cmd_pulse`, `feat_en` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | clock |
| presetn | input | 1 | asynchronous active-low reset |
| psel | input | 1 | bus select |
| penable | input | 1 | access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | ADDR_W | byte address |
| pwdata | input | 32 | write data |
| prdata | output | 32 | read data, valid in the access phase |
| evt_in | input | EVT_W | single-cycle event pulses from the core |
| cmd_pulse | output | CMD_W | command pulses to the core |
| mode_q | output | MODE_W | mode register value |
| feat_en | output | FEAT_W | feature-enable state |
| irq | output | 1 | interrupt request |

## Verification
Read data is combinational from the current register state. It is due during the access phase itself, so the bench samples `prdata` one nanosecond after raising `penable`. Register updates, command pulses, event latching and read-clears all take effect at the access edge. The bench therefore checks `cmd_pulse`, `feat_en`, `mode_q` and `irq` at the falling edge right after that edge, and checks `cmd_pulse` again one cycle later to confirm that it has dropped. For the same-cycle event-and-clear case, the bench drives `evt_in` during the read's access phase and then confirms the result with a following read.

// File: rtl/shadow_regbank_pkg.sv
package shadow_regbank_pkg;
  // Word indices (byte offset / 4)
  localparam int IDX_CTRL  = 0;
  localparam int IDX_MODE  = 1;
  localparam int IDX_STAT  = 2;
  localparam int IDX_FSET  = 4;
  localparam int IDX_FCLR  = 5;
  localparam int IDX_FSTAT = 6;
  localparam int IDX_MSET  = 8;
  localparam int IDX_MCLR  = 9;
  localparam int IDX_MASK  = 10;

  // Next state of a set/clear shadow vector; clear has priority
  function automatic logic [63:0] setclr_next(input logic [63:0] cur,
                                               input logic [63:0] set_v,
                                               input logic [63:0] clr_v);
    return (cur | set_v) & ~clr_v;
  endfunction

  // Next state of an event latch; a new event survives a clear
  function automatic logic [63:0] latch_next(input logic [63:0] cur,
                                              input logic        clr,
                                              input logic [63:0] evt);
    return (clr ? 64'd0 : cur) | evt;
  endfunction
endpackage

// File: rtl/sb_decode.sv
module sb_decode #(
  parameter int ADDR_W = 8
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic [ADDR_W-3:0] idx,
  output logic              wr_ctrl,
  output logic              wr_mode,
  output logic              wr_fset,
  output logic              wr_fclr,
  output logic              wr_mset,
  output logic              wr_mclr,
  output logic              rd_stat
);
  import shadow_regbank_pkg::*;
  localparam int IDX_W = ADDR_W - 2;

  logic wr_acc, rd_acc;
  logic [1:0] unused_lsb;

  assign unused_lsb = paddr[1:0];
  assign idx    = paddr[ADDR_W-1:2];
  assign wr_acc = psel & penable & pwrite;
  assign rd_acc = psel & penable & ~pwrite;

  assign wr_ctrl = wr_acc && (idx == IDX_W'(IDX_CTRL));
  assign wr_mode = wr_acc && (idx == IDX_W'(IDX_MODE));
  assign wr_fset = wr_acc && (idx == IDX_W'(IDX_FSET));
  assign wr_fclr = wr_acc && (idx == IDX_W'(IDX_FCLR));
  assign wr_mset = wr_acc && (idx == IDX_W'(IDX_MSET));
  assign wr_mclr = wr_acc && (idx == IDX_W'(IDX_MCLR));
  assign rd_stat = rd_acc && (idx == IDX_W'(IDX_STAT));
endmodule

// File: rtl/sb_setclr.sv
module sb_setclr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] data,
  output logic [W-1:0] q
);
  import shadow_regbank_pkg::*;
  logic [63:0] nxt;

  always_comb
    nxt = setclr_next(64'(q), set_en ? 64'(data) : 64'd0,
                      clr_en ? 64'(data) : 64'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= nxt[W-1:0];
endmodule

// File: rtl/sb_evt_latch.sv
module sb_evt_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] evt,
  output logic [W-1:0] q
);
  import shadow_regbank_pkg::*;
  logic [63:0] nxt;

  always_comb nxt = latch_next(64'(q), clr, 64'(evt));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= nxt[W-1:0];
endmodule

// File: rtl/shadow_regbank.sv
module shadow_regbank #(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 8,
  parameter int MODE_W = 8,
  parameter int EVT_W  = 4,
  parameter int FEAT_W = 4
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [EVT_W-1:0]  evt_in,
  output logic [CMD_W-1:0]  cmd_pulse,
  output logic [MODE_W-1:0] mode_q,
  output logic [FEAT_W-1:0] feat_en,
  output logic              irq
);
  import shadow_regbank_pkg::*;
  localparam int DATA_W = 32;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int STAT_W = EVT_W + FEAT_W;
  localparam int CLR_BIT = DATA_W - 1;

  // Named internal events (used by the checker)
  logic [IDX_W-1:0]  idx;
  logic              wr_ctrl, wr_mode, wr_fset, wr_fclr, wr_mset, wr_mclr;
  logic              rd_stat, clr_evt;
  logic [EVT_W-1:0]  evt_q;
  logic [STAT_W-1:0] status, imask;
  logic [DATA_W-1:0] unused_wdata;

  assign unused_wdata = pwdata;

  sb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .idx(idx), .wr_ctrl(wr_ctrl), .wr_mode(wr_mode),
    .wr_fset(wr_fset), .wr_fclr(wr_fclr),
    .wr_mset(wr_mset), .wr_mclr(wr_mclr), .rd_stat(rd_stat)
  );

  // Command pulses: one cycle per one-bit written
  assign clr_evt = wr_ctrl & pwdata[CLR_BIT];

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn)     cmd_pulse <= '0;
    else if (wr_ctrl) cmd_pulse <= pwdata[CMD_W-1:0];
    else              cmd_pulse <= '0;

  // Mode register
  always_ff @(posedge pclk or negedge presetn)
    if (!presetn)     mode_q <= '0;
    else if (wr_mode) mode_q <= pwdata[MODE_W-1:0];

  // Feature-enable and interrupt-mask shadow vectors
  sb_setclr #(.W(FEAT_W)) u_feat (
    .clk(pclk), .rst_n(presetn), .set_en(wr_fset), .clr_en(wr_fclr),
    .data(pwdata[FEAT_W-1:0]), .q(feat_en)
  );

  sb_setclr #(.W(STAT_W)) u_mask (
    .clk(pclk), .rst_n(presetn), .set_en(wr_mset), .clr_en(wr_mclr),
    .data(pwdata[STAT_W-1:0]), .q(imask)
  );

  // Event latch, cleared by status read or command bit
  sb_evt_latch #(.W(EVT_W)) u_evt (
    .clk(pclk), .rst_n(presetn), .clr(rd_stat | clr_evt),
    .evt(evt_in), .q(evt_q)
  );

  assign status = {feat_en, evt_q};
  assign irq    = |(status & imask);

  // Read mux; unused bits and write-only offsets read zero
  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (int'(idx))
        IDX_MODE:  prdata = DATA_W'(mode_q);
        IDX_STAT:  prdata = DATA_W'(status);
        IDX_FSTAT: prdata = DATA_W'(feat_en);
        IDX_MASK:  prdata = DATA_W'(imask);
        default:   prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/shadow_regbank_chk.sv
module shadow_regbank_chk #(
  parameter int CMD_W  = 8,
  parameter int MODE_W = 8,
  parameter int EVT_W  = 4,
  parameter int FEAT_W = 4
) (
  input logic                    pclk,
  input logic                    presetn,
  input logic                    wr_ctrl,
  input logic                    wr_mode,
  input logic                    wr_mset,
  input logic                    wr_mclr,
  input logic                    rd_stat,
  input logic                    clr_evt,
  input logic [CMD_W-1:0]        cmd_pulse,
  input logic [MODE_W-1:0]       mode_q,
  input logic [EVT_W+FEAT_W-1:0] imask,
  input logic [EVT_W-1:0]        evt_q,
  input logic                    irq
);
  p_pulse_src_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (|cmd_pulse) |-> $past(wr_ctrl));

  p_pulse_short_r2: assert property (@(posedge pclk) disable iff (!presetn)
    ((|cmd_pulse) && !wr_ctrl) |=> (cmd_pulse == '0));

  p_mode_hold_r3: assert property (@(posedge pclk) disable iff (!presetn)
    !wr_mode |=> $stable(mode_q));

  p_mask_hold_r5: assert property (@(posedge pclk) disable iff (!presetn)
    !(wr_mset || wr_mclr) |=> $stable(imask));

  p_irq_needs_mask_r6: assert property (@(posedge pclk) disable iff (!presetn)
    irq |-> (imask != '0));

  p_evt_sticky_r8: assert property (@(posedge pclk) disable iff (!presetn)
    !(rd_stat || clr_evt) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
endmodule

bind shadow_regbank shadow_regbank_chk #(
  .CMD_W(CMD_W), .MODE_W(MODE_W), .EVT_W(EVT_W), .FEAT_W(FEAT_W)
) u_chk (.*);

// File: tb/test_shadow_regbank.sv
module test_shadow_regbank;
  localparam int ADDR_W = 8, CMD_W = 8, MODE_W = 8, EVT_W = 4, FEAT_W = 4;

  logic              pclk = 0, presetn = 0;
  logic              psel = 0, penable = 0, pwrite = 0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0]       pwdata = '0, prdata;
  logic [EVT_W-1:0]  evt_in = '0;
  logic [CMD_W-1:0]  cmd_pulse;
  logic [MODE_W-1:0] mode_q;
  logic [FEAT_W-1:0] feat_en;
  logic              irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 pclk = ~pclk;

  shadow_regbank #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .MODE_W(MODE_W),
                   .EVT_W(EVT_W), .FEAT_W(FEAT_W)) i_shadow_regbank (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .evt_in(evt_in), .cmd_pulse(cmd_pulse), .mode_q(mode_q),
    .feat_en(feat_en), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Write: setup, access, edge; returns at the falling edge after the edge
  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  // Read with optional event pulse during the access phase
  task automatic bus_rd_evt(input logic [ADDR_W-1:0] a, input logic [EVT_W-1:0] e,
                            output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1; evt_in = e;
    #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0; evt_in = '0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_rd_evt(a, '0, d);
  endtask

  task automatic pulse_evt(input logic [EVT_W-1:0] e);
    @(negedge pclk); evt_in = e;
    @(negedge pclk); evt_in = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R10 cmd_pulse", 32'(cmd_pulse), 0);
    chk("R10 feat_en", 32'(feat_en), 0);
    chk("R10 irq", 32'(irq), 0);
    bus_rd(8'h04, d); chk("R10 mode", d, 0);
    bus_rd(8'h08, d); chk("R10 status", d, 0);
    bus_rd(8'h28, d); chk("R10 mask", d, 0);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    bus_wr(8'h00, 32'h0000_00A5);
    chk("R2 pulse", 32'(cmd_pulse), 32'hA5);
    @(negedge pclk); chk("R2 pulse drop", 32'(cmd_pulse), 0);
    bus_wr(8'h00, 32'h0);
    chk("R2 zero write", 32'(cmd_pulse), 0);
    bus_wr(8'h00, 32'h8000_0000);
    chk("R2 bit31 no pulse", 32'(cmd_pulse), 0);
    bus_rd(8'h00, d); chk("R9 ctrl reads 0", d, 0);
  endtask

  task automatic t_mode;
    logic [31:0] d;
    bus_wr(8'h04, 32'hFFFF_FFFF);
    chk("R3 mode_q", 32'(mode_q), 32'hFF);
    bus_rd(8'h04, d); chk("R9 mode upper zero", d, 32'hFF);
    bus_wr(8'h04, 32'h3C); bus_rd(8'h04, d); chk("R3 mode", d, 32'h3C);
  endtask

  task automatic t_unaligned;
    logic [31:0] d;
    bus_wr(8'h06, 32'h5A); bus_rd(8'h07, d); chk("R1 byte addr", d, 32'h5A);
    bus_rd(8'h04, d); chk("R1 word addr", d, 32'h5A);
  endtask

  task automatic t_feat;
    logic [31:0] d;
    bus_wr(8'h10, 32'h5); chk("R4 set", 32'(feat_en), 32'h5);
    bus_wr(8'h10, 32'h2); bus_rd(8'h18, d); chk("R4 set more", d, 32'h7);
    bus_wr(8'h14, 32'h4); bus_rd(8'h18, d); chk("R4 clear", d, 32'h3);
    bus_wr(8'h14, 32'h0); bus_wr(8'h10, 32'h0);
    bus_rd(8'h18, d); chk("R4 zero no effect", d, 32'h3);
    bus_rd(8'h10, d); chk("R9 set addr reads 0", d, 0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    bus_wr(8'h08, 32'hFF);
    bus_rd(8'h08, d); chk("R7 layout / write ignored", d, 32'h30);
  endtask

  task automatic t_events;
    logic [31:0] d;
    pulse_evt(4'h9);
    bus_rd(8'h08, d); chk("R8 latched", d, 32'h39);
    bus_rd(8'h08, d); chk("R8 read clears", d, 32'h30);
    pulse_evt(4'h4);
    bus_wr(8'h00, 32'h8000_0000);
    bus_rd(8'h08, d); chk("R8 cmd clears", d, 32'h30);
    pulse_evt(4'h1);
    bus_rd_evt(8'h08, 4'h2, d); chk("R8 before clear", d, 32'h31);
    bus_rd(8'h08, d); chk("R8 new event survives", d, 32'h32);
    bus_rd(8'h08, d); chk("R8 cleared", d, 32'h30);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    bus_wr(8'h14, 32'hF);
    bus_wr(8'h20, 32'h10); chk("R6 masked off source", 32'(irq), 0);
    bus_wr(8'h10, 32'h1);  chk("R6 feature+mask", 32'(irq), 1);
    bus_rd(8'h28, d); chk("R5 mask read", d, 32'h10);
    bus_wr(8'h24, 32'h10); chk("R5 mask clear irq", 32'(irq), 0);
    bus_wr(8'h20, 32'h01); pulse_evt(4'h1);
    chk("R6 event irq", 32'(irq), 1);
    bus_rd(8'h08, d); chk("R6 irq after read", 32'(irq), 0);
    bus_wr(8'h28, 32'hFF); bus_wr(8'h20, 32'h0); bus_wr(8'h24, 32'h0);
    bus_rd(8'h28, d); chk("R5 write ignored", d, 32'h01);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    bus_rd(8'h3C, d); chk("R9 unmapped", d, 0);
    bus_rd(8'h20, d); chk("R9 mask-set reads 0", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge pclk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);
    t_reset; t_ctrl; t_mode; t_unaligned; t_feat;
    t_status; t_events; t_irq; t_unmapped;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule